// File: doc/BRIEF.md
# Circular Self-Test Path Wrapper

This block wraps a small combinational circuit under test, a 4-bit ripple adder, with a closed ring of flip-flops. The same ring produces the stimulus and compacts the responses, so there is no separate pattern generator or signature register. During a self-test run, the ring drives all nine adder inputs. On every clock each ring cell loads its predecessor XORed with one adder output. After a programmed number of clocks, the ring contents are the signature. The block compares the signature with a fault-free value supplied from outside and reports pass or fail.

When no run is active, the adder computes from the functional operand inputs and the ring holds its value. Runs start with a one-cycle start pulse while self-test is enabled. A run loads the seed, which is replaced by a nonzero default if the seed is zero, and a down-counter. A verification-only input can force any one sum bit to a stuck value. This shows that the compare catches a defect.

Top module: `cstp_wrap`

## Requirements
- R1: After reset the ring (the `signature` output) holds the default seed 4'b1001, and `done` and `pass` are 0.
- R2: A start accepted with self-test enabled loads the ring from `seed`. An all-zero `seed` is replaced by 4'b1001.
- R3: While a run is active, adder operand A equals the ring, and operand B equals the ring rotated by two: B = {ring[1:0], ring[3:2]}. The carry-in is the inverse of ring bit 0. The adder result is visible on `sum_out`/`cout`.
- R4: Each run clock, ring bit i (i = 1..3) becomes ring bit i-1 XOR sum bit i. Bit 0 becomes ring bit 3 XOR sum bit 0. Bit 3 additionally takes the carry-out into its XOR.
- R5: A run with count N steps the ring exactly N times. `done` rises on the clock edge N+1 edges after the edge that accepted start. With N = 0, the signature equals the loaded seed.
- R6: At completion, `pass` is 1 exactly when the signature equals `golden`. `done`, `pass` and the signature stay constant until the next accepted start.
- R7: With no run active, `sum_out`/`cout` equal `op_a + op_b + cin`, and the ring does not change.
- R8: A start is ignored when `bist_en` is 0 or while a run is active. The run in progress completes with the same signature it would have produced anyway.
- R9: When `flt_en` is 1, sum bit `flt_sel` is forced to `flt_val` in both modes. A run with a stuck sum bit yields the signature of the faulty adder, and `pass` drops when that signature differs from the fault-free value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en | input | 1 | Enables acceptance of start |
| start | input | 1 | One-cycle pulse that begins a run |
| seed | input | 4 | Ring start value (zero replaced by default) |
| cycles | input | 16 | Number of ring steps per run |
| golden | input | 4 | Fault-free signature to compare against |
| op_a | input | 4 | Functional operand A |
| op_b | input | 4 | Functional operand B |
| cin | input | 1 | Functional carry-in |
| flt_en | input | 1 | Enables stuck-at injection on a sum bit |
| flt_sel | input | 2 | Index of the forced sum bit |
| flt_val | input | 1 | Stuck value for the forced bit |
| sum_out | output | 4 | Adder sum |
| cout | output | 1 | Adder carry-out |
| signature | output | 4 | Current ring contents |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | Signature matched golden; held with done |

## Verification
A table of runs uses several seeds, including zero, and run lengths from 0 to 40. Each run is compared against an independent ring model. Runs of different lengths separate an off-by-one step count from a correct one. The zero-length run isolates the seed path. Fault rows on each sum bit, at both stuck values, show that the ring mixes every adder output into the signature. A one-step hand-worked run pins down the operand mapping and feedback taps exactly. Directed cases cover the functional pass-through, ring hold when idle, and starts that must be refused.

// File: rtl/cstp_pkg.sv
package cstp_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_RUN  = 2'd1,
    CTL_DONE = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/cstp_cut.sv
// Circuit under test: ripple adder with a stuck-at override on one sum bit.
module cstp_cut #(
  parameter int unsigned W = 4,
  localparam int unsigned SEL_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             cin_i,
  input  logic             flt_en_i,
  input  logic [SEL_W-1:0] flt_sel_i,
  input  logic             flt_val_i,
  output logic [W-1:0]     sum_o,
  output logic             cout_o
);
  logic [W:0] total;

  always_comb begin
    total = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  end

  assign cout_o = total[W];

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = (flt_en_i && (flt_sel_i == SEL_W'(i))) ? flt_val_i : total[i];
  end
endmodule

// File: rtl/cstp_ring.sv
// Closed ring of cells: pattern source for the adder and response compactor.
module cstp_ring #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] DEF_SEED = 4'b1001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] seed_i,
  input  logic [W-1:0] sum_i,
  input  logic         cout_i,
  output logic [W-1:0] ring_o,
  output logic [W-1:0] opa_o,
  output logic [W-1:0] opb_o,
  output logic         ocin_o
);
  localparam int unsigned ROT = W / 2;

  logic [W-1:0] ring_q, ring_d, fold, seed_ok;
  logic         ring_en;

  assign seed_ok = (seed_i == '0) ? DEF_SEED : seed_i;

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == W - 1) begin : g_last
      assign fold[i] = ring_q[(i + W - 1) % W] ^ sum_i[i] ^ cout_i;
    end else begin : g_mid
      assign fold[i] = ring_q[(i + W - 1) % W] ^ sum_i[i];
    end
    assign opb_o[i] = ring_q[(i + ROT) % W];
  end

  assign opa_o  = ring_q;
  assign ocin_o = ~ring_q[0];
  assign ring_o = ring_q;

  assign ring_en = load_i | step_i;

  always_comb begin
    ring_d = ring_q;
    if (load_i)      ring_d = seed_ok;
    else if (step_i) ring_d = fold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ring_q <= DEF_SEED;
    else if (ring_en) ring_q <= ring_d;
  end

  AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ring_q != '0)); // R2
  AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(ring_q)); // R7
endmodule

// File: rtl/cstp_ctl.sv
// Run sequencer: start acceptance, step counter, completion and compare.
module cstp_ctl
  import cstp_pkg::*;
#(
  parameter int unsigned W     = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bist_en_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic [W-1:0]     sig_i,
  input  logic [W-1:0]     golden_i,
  output logic             load_o,
  output logic             step_o,
  output logic             run_o,
  output logic             done_o,
  output logic             pass_o
);
  ctl_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pass_q, pass_d;
  logic             cnt_en;

  assign run_o  = (st_q == CTL_RUN);
  assign load_o = start_i && bist_en_i && !run_o;
  assign step_o = run_o && (cnt_q != '0);
  assign cnt_en = load_o | step_o;
  assign done_o = (st_q == CTL_DONE);
  assign pass_o = pass_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pass_d = pass_q;
    unique case (st_q)
      CTL_RUN: begin
        if (cnt_q == '0) begin
          st_d   = CTL_DONE;
          pass_d = (sig_i == golden_i);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        if (load_o) begin
          st_d   = CTL_RUN;
          cnt_d  = cycles_i;
          pass_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CTL_IDLE;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (run_o && cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && cnt_q == '0) |=> (done_o && !run_o)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && start_i && cnt_q != '0) |=> (run_o && cnt_q == $past(cnt_q) - CNT_W'(1))); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_o) |=> (done_o && $stable(pass_o))); // R6
  AST_DONE_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && run_o)); // R6
endmodule

// File: rtl/cstp_wrap.sv
// Top: reset synchroniser, operand selection, ring, adder and sequencer.
module cstp_wrap #(
  parameter int unsigned  W        = 4,
  parameter int unsigned  CNT_W    = 16,
  parameter logic [W-1:0] DEF_SEED = 4'b1001,
  localparam int unsigned SEL_W    = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bist_en,
  input  logic             start,
  input  logic [W-1:0]     seed,
  input  logic [CNT_W-1:0] cycles,
  input  logic [W-1:0]     golden,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic             cin,
  input  logic             flt_en,
  input  logic [SEL_W-1:0] flt_sel,
  input  logic             flt_val,
  output logic [W-1:0]     sum_out,
  output logic             cout,
  output logic [W-1:0]     signature,
  output logic             done,
  output logic             pass
);
  logic [1:0]   rst_sync_q;
  logic         rst_sync_n;
  logic         load, step, run;
  logic [W-1:0] ring_a, ring_b, cut_a, cut_b, cut_sum;
  logic         ring_cin, cut_cin, cut_cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign cut_a   = run ? ring_a   : op_a;
  assign cut_b   = run ? ring_b   : op_b;
  assign cut_cin = run ? ring_cin : cin;

  cstp_cut #(.W(W)) i_cut (
    .a_i       (cut_a),
    .b_i       (cut_b),
    .cin_i     (cut_cin),
    .flt_en_i  (flt_en),
    .flt_sel_i (flt_sel),
    .flt_val_i (flt_val),
    .sum_o     (cut_sum),
    .cout_o    (cut_cout)
  );

  cstp_ring #(.W(W), .DEF_SEED(DEF_SEED)) i_ring (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (load),
    .step_i (step),
    .seed_i (seed),
    .sum_i  (cut_sum),
    .cout_i (cut_cout),
    .ring_o (signature),
    .opa_o  (ring_a),
    .opb_o  (ring_b),
    .ocin_o (ring_cin)
  );

  cstp_ctl #(.W(W), .CNT_W(CNT_W)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start),
    .bist_en_i (bist_en),
    .cycles_i  (cycles),
    .sig_i     (signature),
    .golden_i  (golden),
    .load_o    (load),
    .step_o    (step),
    .run_o     (run),
    .done_o    (done),
    .pass_o    (pass)
  );

  assign sum_out = cut_sum;
  assign cout    = cut_cout;

  AST_IDLE_OPERANDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !flt_en) |-> ({cout, sum_out} == ({1'b0, op_a} + {1'b0, op_b} + {4'b0, cin}))); // R7
  AST_RUN_OPERAND_A: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run |-> (cut_a == signature)); // R3
endmodule

// File: tb/test_cstp_wrap.sv
`timescale 1ns/1ps
module test_cstp_wrap;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bist_en, start, cin, flt_en, flt_val;
  logic [3:0]  seed, golden, op_a, op_b;
  logic [15:0] cycles;
  logic [1:0]  flt_sel;
  logic [3:0]  sum_out, signature;
  logic        cout, done, pass;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cstp_wrap i_cstp_wrap (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .start(start), .seed(seed),
    .cycles(cycles), .golden(golden), .op_a(op_a), .op_b(op_b), .cin(cin),
    .flt_en(flt_en), .flt_sel(flt_sel), .flt_val(flt_val), .sum_out(sum_out),
    .cout(cout), .signature(signature), .done(done), .pass(pass)
  );

  // seed, steps, fault enable, fault bit, stuck value
  localparam logic [15:0] VEC [8] = '{
    {4'h9, 8'd20, 1'b0, 2'd0, 1'b0},
    {4'hA, 8'd33, 1'b0, 2'd0, 1'b0},
    {4'h0, 8'd12, 1'b0, 2'd0, 1'b0},
    {4'h5, 8'd0,  1'b0, 2'd0, 1'b0},
    {4'h9, 8'd25, 1'b1, 2'd0, 1'b0},
    {4'h3, 8'd18, 1'b1, 2'd3, 1'b1},
    {4'hF, 8'd40, 1'b1, 2'd2, 1'b1},
    {4'h6, 8'd1,  1'b1, 2'd1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_sig(input logic [3:0] sd, input int n,
                                         input logic fe, input logic [1:0] fb, input logic fv);
    logic [3:0] r, a, b, s, nx;
    logic [4:0] t;
    logic       c;
    r = (sd == 4'h0) ? 4'h9 : sd;
    for (int k = 0; k < n; k++) begin
      a = r;
      b = {r[1:0], r[3:2]};
      t = {1'b0, a} + {1'b0, b} + {4'b0, ~r[0]};
      s = t[3:0];
      c = t[4];
      if (fe) s[fb] = fv;
      nx[0] = r[3] ^ s[0];
      nx[1] = r[0] ^ s[1];
      nx[2] = r[1] ^ s[2];
      nx[3] = r[2] ^ s[3] ^ c;
      r = nx;
    end
    return r;
  endfunction

  // Starts a run and checks that done rises exactly N+1 edges after start is taken.
  task automatic run_bist(input logic [3:0] sd, input int n, input logic fe,
                          input logic [1:0] fb, input logic fv, input logic [3:0] gold);
    int early;
    seed = sd; cycles = 16'(n); golden = gold;
    flt_en = fe; flt_sel = fb; flt_val = fv; bist_en = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    early = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (done) early++;
    end
    @(negedge clk);
    chk("R5 done timing", {31'b0, (early == 0) && done}, 32'd1);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] gold, exp_sig, held;
    rst_n = 1'b0; bist_en = 1'b0; start = 1'b0; seed = 4'h0; cycles = '0;
    golden = 4'h0; op_a = 4'h0; op_b = 4'h0; cin = 1'b0;
    flt_en = 1'b0; flt_sel = 2'd0; flt_val = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 signature", 32'(signature), 32'h9);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 pass", 32'(pass), 32'h0);

    // R7 functional pass-through and ring hold
    op_a = 4'h7; op_b = 4'h9; cin = 1'b1; #1;
    chk("R7 sum", 32'(sum_out), 32'h1);
    chk("R7 cout", 32'(cout), 32'h1);
    op_a = 4'h3; op_b = 4'h4; cin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 sum2", 32'({cout, sum_out}), 32'h07);
    chk("R7 ring hold", 32'(signature), 32'h9);

    // R8 start ignored while bist_en low
    bist_en = 1'b0; seed = 4'h6; cycles = 16'd3;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 disabled start sig", 32'(signature), 32'h9);
    chk("R8 disabled start done", 32'(done), 32'h0);

    // R3 operand mapping and R4 one-step feedback, hand-worked from seed 1001
    seed = 4'h9; cycles = 16'd1; golden = 4'hC; bist_en = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R3 sum from ring", 32'(sum_out), 32'hF);
    chk("R3 cout from ring", 32'(cout), 32'h0);
    repeat (2) @(negedge clk);
    chk("R4 one step signature", 32'(signature), 32'hC);
    chk("R6 pass on match", 32'(pass), 32'h1);
    repeat (3) @(negedge clk);
    chk("R6 held", 32'({done, pass, signature}), 32'h3C);

    // R9 stuck sum bit 0 at 0: signature 1101, pass low
    run_bist(4'h9, 1, 1'b1, 2'd0, 1'b0, 4'hC);
    chk("R9 faulty signature", 32'(signature), 32'hD);
    chk("R9 fault flagged", 32'(pass), 32'h0);
    flt_en = 1'b0;

    // Vector table against the reference ring
    foreach (VEC[i]) begin
      logic [3:0] vs; int vn; logic vfe; logic [1:0] vfb; logic vfv;
      {vs, vn[7:0], vfe, vfb, vfv} = {VEC[i][15:12], VEC[i][11:4], VEC[i][3], VEC[i][2:1], VEC[i][0]};
      vn = int'(VEC[i][11:4]);
      gold = ref_sig(vs, vn, 1'b0, 2'd0, 1'b0);
      exp_sig = ref_sig(vs, vn, vfe, vfb, vfv);
      run_bist(vs, vn, vfe, vfb, vfv, gold);
      chk(vfe ? "R9 table signature" : "R4 table signature", 32'(signature), 32'(exp_sig));
      chk("R6 table pass", 32'(pass), {31'b0, exp_sig == gold});
      if (vn == 0) chk("R2 zero-length seed", 32'(signature), 32'(vs == 4'h0 ? 4'h9 : vs));
      if (vs == 4'h0) chk("R2 zero seed default", 32'(signature), 32'(ref_sig(4'h9, vn, 1'b0, 2'd0, 1'b0)));
    end
    flt_en = 1'b0;

    // R2 zero seed with no steps
    run_bist(4'h0, 0, 1'b0, 2'd0, 1'b0, 4'h9);
    chk("R2 zero seed replaced", 32'(signature), 32'h9);

    // R8 start during an active run is ignored
    gold = ref_sig(4'h9, 30, 1'b0, 2'd0, 1'b0);
    seed = 4'h9; cycles = 16'd30; golden = gold; bist_en = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    seed = 4'h3; cycles = 16'd2;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8 restart ignored sig", 32'(signature), 32'(gold));
    chk("R8 restart ignored pass", 32'({done, pass}), 32'h3);

    // R6 held after completion while inputs change and bist_en is low
    held = signature;
    bist_en = 1'b0; golden = ~gold; op_a = 4'hF; op_b = 4'h1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 result held", 32'({done, pass, signature}), 32'({2'b11, held}));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule